// File: doc/BRIEF.md
# Root Clock Generator with Fractional M/N Divider

This block produces a derived root clock from one of several source clocks. The chosen source passes through a pre-divider that can divide by half-integer ratios. It then passes through an optional fractional M/N stage, whose output high time is set by a separate duty register. Everything runs on one reference clock, `clk`. Each source is presented as a per-cycle edge qualifier (`src_tick`), so a source running at half the reference rate ticks on every reference cycle. The derived clock appears as a level (`out_clk`) and as a one-cycle marker per output period (`out_pulse`).

Software writes shadow registers through a simple write port and reads them back through a combinational read port. Nothing reaches the running divider until software sets the commit bit in the command register. The hardware copies the shadow set into the active set at the next output-period boundary, or at once if the root is idle. It clears the commit bit in the same edge, and software polls for that. The N and D registers hold complemented encodings, which the hardware decodes. A root whose output has stopped reports this through a status bit. A safe two-step reprogramming sequence (park on a safe source, then switch to the target) gives the correct rate after each commit.

Top module: `rcg_root`

## Requirements
- R1: After reset the active setting is source 0, pre-divider bypass and M/N bypass. Command bit 0 (commit) reads 0. Command bit 31 (root idle) reads 1 until the first output pulse and 0 afterwards. With source 0 ticking every cycle, `out_pulse` fires once every 2 cycles.
- R2: Word addresses are 0 command, 1 config, 2 M, 3 N, 4 D. Config bits [HID_W-1:0] hold the pre-divider, bits [10:8] the source index, bits [13:12] the mode, and bit 16 a stored hardware-control flag. Reads of addresses 1 to 4 return the full written shadow word.
- R3: Writes to config, M, N or D do not change the output until a commit takes effect.
- R4: Writing 1 to command bit 0 sets the commit flag, which reads 1 on the next cycle. The flag clears in the same edge that copies shadow to active. That edge is the next output-pulse boundary, or any edge while the root is idle. Writing 0 to bit 0 does not cancel a pending commit.
- R5: A pre-divider value h of 0 gives one output period per 2 source edges. A nonzero h gives one per h+1 source edges, which yields half-integer ratios.
- R6: The source index selects which `src_tick` bit drives the pre-divider.
- R7: With mode nonzero and 0 < M < N, the output gives M pulses every N pre-divider periods. M is the low MND_W bits of the M register. N is the bitwise complement of the N register's low MND_W bits plus M, modulo 2^MND_W.
- R8: Mode 0, a decoded N of 0, M of 0, or M not below N all bypass the M/N stage, so the output never stalls.
- R9: In M/N mode `out_clk` is high while the accumulator is below half of the complemented D field. In bypass mode it is high while the pre-divider count is below (h_eff+1)/2, where h_eff is 1 for h=0 and h otherwise.
- R10: After OFF_TIMEOUT cycles without an output pulse, root idle reads 1 and no pulse appears. A commit then takes effect without waiting for a boundary.
- R11: Parking on a safe source with one commit, then committing the target source and dividers, gives the correct rate after each commit.
- R12: `out_pulse` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick | input | NUM_SRC | Per-cycle edge qualifier of each source clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| out_clk | output | 1 | Derived root clock level |
| out_pulse | output | 1 | One-cycle marker per output period |

## Verification
The rate is measured by counting `out_pulse` over windows that are whole multiples of the expected period. Sources tick every cycle, every second cycle, every third cycle or never. Pre-divider values of 0, 2 and 5 separate the bypass case from half-integer and odd ratios. The M/N ratios 1/3 and 2/5 separate a single pulse per wrap from uneven pulse spacing. Cases with N of 0, M equal to N and mode 0 must all reproduce the bypass rate. Two D values give high-time counts of one half and one quarter. The dead source shows that the idle flag rises and that a commit still lands.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

   localparam int DATA_W       = 32;
   localparam int ADDR_W       = 3;
   localparam int CMD_UPD_BIT  = 0;
   localparam int CMD_IDLE_BIT = 31;
   localparam int CFG_SRC_LSB  = 8;
   localparam int CFG_SRC_MAXW = 3;
   localparam int CFG_MODE_LSB = 12;
   localparam int CFG_MODE_W   = 2;

   typedef enum logic [ADDR_W-1:0] {
      RA_CMD = 3'd0,
      RA_CFG = 3'd1,
      RA_MVAL = 3'd2,
      RA_NVAL = 3'd3,
      RA_DVAL = 3'd4
   } rcg_addr_e;

endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
   import rcg_pkg::*;
#(
   parameter int SRC_W = 2,
   parameter int HID_W = 5,
   parameter int MND_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   input  logic                  root_idle,
   input  logic                  commit_ok,
   output logic                  commit,
   output logic [SRC_W-1:0]      act_src,
   output logic [HID_W-1:0]      act_hid,
   output logic [CFG_MODE_W-1:0] act_mode,
   output logic [MND_W-1:0]      act_m,
   output logic [MND_W-1:0]      act_nreg,
   output logic [MND_W-1:0]      act_dreg
);

   logic [DATA_W-1:0] sh_cfg, sh_m, sh_n, sh_d;
   logic              upd_q;
   logic              set_upd;

   assign set_upd = wr_en && (wr_addr == RA_CMD) && wr_data[CMD_UPD_BIT];
   assign commit  = upd_q && commit_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_cfg <= '0;
         sh_m   <= '0;
         sh_n   <= '0;
         sh_d   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_CFG:  sh_cfg <= wr_data;
            RA_MVAL: sh_m   <= wr_data;
            RA_NVAL: sh_n   <= wr_data;
            RA_DVAL: sh_d   <= wr_data;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_q <= 1'b0;
      end else if (set_upd) begin
         upd_q <= 1'b1;
      end else if (commit) begin
         upd_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_src  <= '0;
         act_hid  <= '0;
         act_mode <= '0;
         act_m    <= '0;
         act_nreg <= '0;
         act_dreg <= '0;
      end else if (commit) begin
         act_src  <= sh_cfg[CFG_SRC_LSB +: SRC_W];
         act_hid  <= sh_cfg[HID_W-1:0];
         act_mode <= sh_cfg[CFG_MODE_LSB +: CFG_MODE_W];
         act_m    <= sh_m[MND_W-1:0];
         act_nreg <= sh_n[MND_W-1:0];
         act_dreg <= sh_d[MND_W-1:0];
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         RA_CMD: begin
            rd_data[CMD_UPD_BIT]  = upd_q;
            rd_data[CMD_IDLE_BIT] = root_idle;
         end
         RA_CFG:  rd_data = sh_cfg;
         RA_MVAL: rd_data = sh_m;
         RA_NVAL: rd_data = sh_n;
         RA_DVAL: rd_data = sh_d;
         default: rd_data = '0;
      endcase
   end

   // R4: a granted commit clears the flag unless software sets it again
   p_commit_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_q && commit_ok && !set_upd) |=> !upd_q);

   // R3: the active set only moves on a commit
   p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(act_src) && $stable(act_hid) && $stable(act_mode)
                   && $stable(act_m) && $stable(act_nreg) && $stable(act_dreg)));

endmodule

// File: rtl/rcg_prediv.sv
module rcg_prediv #(
   parameter int HID_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [HID_W-1:0] hid,
   output logic             pre_tick,
   output logic             phase_hi
);

   logic [HID_W-1:0] cnt_q;
   logic [HID_W-1:0] h_eff;
   logic [HID_W:0]   half_lim;

   // a zero setting behaves as a divide by two edges (rate unchanged)
   assign h_eff    = (hid == '0) ? HID_W'(1) : hid;
   assign half_lim = ({1'b0, h_eff} + (HID_W+1)'(1)) >> 1;
   assign pre_tick = tick && (cnt_q == h_eff);
   assign phase_hi = ({1'b0, cnt_q} < half_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= pre_tick ? '0 : cnt_q + HID_W'(1);
      end
   end

   // R5: the edge counter never passes its terminal value
   p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= h_eff);

endmodule

// File: rtl/rcg_mnd.sv
module rcg_mnd #(
   parameter int MND_W   = 8,
   parameter bit HAS_MND = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [1:0]       mode,
   input  logic [MND_W-1:0] m_val,
   input  logic [MND_W-1:0] nreg,
   input  logic [MND_W-1:0] dreg,
   output logic             fire,
   output logic             duty_hi,
   output logic             mn_on
);

   generate
      if (HAS_MND) begin : g_mnd
         logic [MND_W-1:0] acc_q;
         logic [MND_W-1:0] n_val;
         logic [MND_W-1:0] d_val;
         logic [MND_W:0]   sum;
         logic             wrap;

         assign n_val   = (~nreg) + m_val;
         assign d_val   = ~dreg;
         assign mn_on   = (mode != 2'd0) && (m_val != '0) && (m_val < n_val);
         assign sum     = {1'b0, acc_q} + {1'b0, m_val};
         assign wrap    = (sum >= {1'b0, n_val});
         assign fire    = mn_on ? wrap : 1'b1;
         assign duty_hi = (acc_q < (d_val >> 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (clr) begin
               acc_q <= '0;
            end else if (adv && mn_on) begin
               acc_q <= wrap ? MND_W'(sum - {1'b0, n_val}) : sum[MND_W-1:0];
            end
         end

         // R7: the accumulator stays below the decoded modulus
         p_acc_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            mn_on |-> (acc_q < n_val));
      end else begin : g_nomnd
         assign mn_on   = 1'b0;
         assign fire    = 1'b1;
         assign duty_hi = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/rcg_root.sv
module rcg_root
   import rcg_pkg::*;
#(
   parameter int NUM_SRC     = 4,
   parameter int HID_W       = 5,
   parameter int MND_W       = 8,
   parameter bit HAS_MND     = 1'b1,
   parameter int OFF_TIMEOUT = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic               wr_en,
   input  logic [2:0]         wr_addr,
   input  logic [31:0]        wr_data,
   input  logic [2:0]         rd_addr,
   output logic [31:0]        rd_data,
   output logic               out_clk,
   output logic               out_pulse
);

   localparam int SRC_W  = $clog2(NUM_SRC);
   localparam int IDLE_W = $clog2(OFF_TIMEOUT + 1);

   generate
      if (NUM_SRC < 2 || SRC_W > CFG_SRC_MAXW) begin : g_bad_src
         $error("rcg_root: NUM_SRC must lie in 2..8");
      end
      if (HID_W < 1 || HID_W > CFG_SRC_LSB) begin : g_bad_hid
         $error("rcg_root: HID_W must lie in 1..8");
      end
      if (MND_W < 2 || MND_W > 31) begin : g_bad_mnd
         $error("rcg_root: MND_W must lie in 2..31");
      end
      if (OFF_TIMEOUT < 4) begin : g_bad_to
         $error("rcg_root: OFF_TIMEOUT too small");
      end
   endgenerate

   logic              commit, commit_ok;
   logic [SRC_W-1:0]  act_src;
   logic [HID_W-1:0]  act_hid;
   logic [1:0]        act_mode;
   logic [MND_W-1:0]  act_m, act_nreg, act_dreg;
   logic              sel_tick, pre_tick, phase_hi;
   logic              fire, duty_hi, mn_on;
   logic              pulse_now;
   logic              pulse_q, idle_q;
   logic [IDLE_W-1:0] idle_cnt;

   rcg_regs #(.SRC_W(SRC_W), .HID_W(HID_W), .MND_W(MND_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .root_idle(idle_q), .commit_ok(commit_ok), .commit(commit),
      .act_src(act_src), .act_hid(act_hid), .act_mode(act_mode),
      .act_m(act_m), .act_nreg(act_nreg), .act_dreg(act_dreg)
   );

   generate
      if (NUM_SRC == (1 << SRC_W)) begin : g_sel_full
         assign sel_tick = src_tick[act_src];
      end else begin : g_sel_part
         assign sel_tick = (int'(act_src) < NUM_SRC) ? src_tick[act_src] : 1'b0;
      end
   endgenerate

   rcg_prediv #(.HID_W(HID_W)) u_prediv (
      .clk(clk), .rst_n(rst_n), .clr(commit), .tick(sel_tick),
      .hid(act_hid), .pre_tick(pre_tick), .phase_hi(phase_hi)
   );

   rcg_mnd #(.MND_W(MND_W), .HAS_MND(HAS_MND)) u_mnd (
      .clk(clk), .rst_n(rst_n), .clr(commit), .adv(pre_tick),
      .mode(act_mode), .m_val(act_m), .nreg(act_nreg), .dreg(act_dreg),
      .fire(fire), .duty_hi(duty_hi), .mn_on(mn_on)
   );

   assign pulse_now = pre_tick && fire;
   assign commit_ok = pulse_now || idle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q  <= 1'b0;
         idle_q   <= 1'b1;
         idle_cnt <= IDLE_W'(OFF_TIMEOUT);
      end else begin
         pulse_q <= pulse_now;
         if (pulse_now) begin
            idle_cnt <= '0;
            idle_q   <= 1'b0;
         end else if (idle_cnt == IDLE_W'(OFF_TIMEOUT)) begin
            idle_q   <= 1'b1;
         end else begin
            idle_cnt <= idle_cnt + IDLE_W'(1);
         end
      end
   end

   assign out_pulse = pulse_q;
   assign out_clk   = mn_on ? duty_hi : phase_hi;

   // R12: at least two reference cycles per output period
   p_no_back2back_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

   // R10: an idle root reports no pulse
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      idle_q |-> !pulse_q);

endmodule

// File: tb/test_rcg_root.sv
module test_rcg_root;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_tick = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        out_clk, out_pulse;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   rcg_root i_rcg_root (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .out_clk(out_clk), .out_pulse(out_pulse)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // source 0 every cycle, 1 every second, 2 every third, 3 never
   initial begin
      int phase = 0;
      forever begin
         @(negedge clk);
         phase++;
         src_tick[0] = 1'b1;
         src_tick[1] = (phase % 2 == 0);
         src_tick[2] = (phase % 3 == 0);
         src_tick[3] = 1'b0;
      end
   end

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic do_commit(input string req);
      logic [31:0] v;
      bit cleared = 1'b0;
      wr(3'd0, 32'd1);
      rd(3'd0, v);
      check({req, "/R4 flag set"}, v[0], 1);
      for (int i = 0; i < 400 && !cleared; i++) begin
         rd(3'd0, v);
         if (!v[0]) cleared = 1'b1;
      end
      check({req, "/R4 flag cleared"}, cleared, 1);
      repeat (40) @(negedge clk);
   endtask

   task automatic count_pulses(input int ncyc, output int cnt, output int b2b);
      bit prev = 1'b0;
      cnt = 0; b2b = 0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if (out_pulse) cnt++;
         if (out_pulse && prev) b2b++;
         prev = out_pulse;
      end
   endtask

   task automatic count_high(input int ncyc, output int cnt);
      cnt = 0;
      for (int i = 0; i < ncyc; i++) begin
         @(negedge clk);
         if (out_clk) cnt++;
      end
   endtask

   task automatic rate(input string req, input int ncyc, input int exp);
      int c, b;
      count_pulses(ncyc, c, b);
      check(req, c, exp);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      int c, b;
      rd(3'd0, v);
      check("R1 commit flag after reset", v[0], 0);
      check("R1 idle before first pulse", v[31], 1);
      repeat (10) @(negedge clk);
      rd(3'd0, v);
      check("R1 idle cleared", v[31], 0);
      count_pulses(200, c, b);
      check("R1 default rate", c, 100);
      check("R12 no back-to-back pulses", b, 0);
   endtask

   task automatic t_shadow();
      logic [31:0] v;
      wr(3'd1, 32'h0001_0005);
      rate("R3 shadow write ignored", 200, 100);
      rd(3'd1, v);
      check("R2 config readback", v, 32'h0001_0005);
      wr(3'd2, 32'hA5A5_0000);
      rd(3'd2, v);
      check("R2 M readback", v, 32'hA5A5_0000);
      do_commit("R5 h5");
      rate("R5 pre-divider h=5", 300, 50);
      wr(3'd1, 32'd2);
      do_commit("R5 h2");
      rate("R5 pre-divider h=2", 300, 100);
   endtask

   task automatic t_src();
      wr(3'd1, 32'h0000_0100);
      do_commit("R6 src1");
      rate("R6 source 1", 400, 100);
      wr(3'd1, 32'h0000_0200);
      do_commit("R6 src2");
      rate("R6 source 2", 600, 100);
   endtask

   task automatic t_mnd();
      wr(3'd1, 32'h0000_1000);
      wr(3'd2, 32'd1);
      wr(3'd3, ~32'd2);
      wr(3'd4, ~32'd3);
      do_commit("R7 1/3");
      rate("R7 M/N 1/3", 600, 100);
      wr(3'd2, 32'd2);
      wr(3'd3, ~32'd3);
      do_commit("R7 2/5");
      rate("R7 M/N 2/5", 500, 100);
   endtask

   task automatic t_bypass();
      wr(3'd2, 32'd0);
      wr(3'd3, 32'hFFFF_FFFF);
      do_commit("R8 n0");
      rate("R8 N=0 bypass", 200, 100);
      wr(3'd2, 32'd3);
      wr(3'd3, 32'hFFFF_FFFF);
      do_commit("R8 m=n");
      rate("R8 M=N bypass", 200, 100);
      wr(3'd1, 32'd0);
      wr(3'd2, 32'd1);
      wr(3'd3, ~32'd2);
      do_commit("R8 mode0");
      rate("R8 mode 0 bypass", 200, 100);
   endtask

   task automatic t_duty();
      int h;
      count_high(200, h);
      check("R9 bypass high time", h, 100);
      wr(3'd1, 32'h0000_1000);
      wr(3'd2, 32'd1);
      wr(3'd3, ~32'd3);
      wr(3'd4, ~32'd4);
      do_commit("R9 d4");
      count_high(800, h);
      check("R9 half duty", h, 400);
      rate("R7 M/N 1/4", 800, 100);
      wr(3'd4, ~32'd2);
      do_commit("R9 d2");
      count_high(800, h);
      check("R9 quarter duty", h, 200);
   endtask

   task automatic t_idle();
      logic [31:0] v;
      bit cleared = 1'b0;
      wr(3'd1, 32'h0000_0300);
      do_commit("R10 dead src");
      repeat (300) @(negedge clk);
      rd(3'd0, v);
      check("R10 idle flag", v[31], 1);
      rate("R10 no pulses", 100, 0);
      wr(3'd1, 32'd0);
      do_commit("R10 escape");
      rd(3'd0, v);
      check("R10 idle cleared after escape", v[31], 0);
      rate("R10 rate after escape", 200, 100);
      // pending commit is not cancelled by a zero write
      wr(3'd1, 32'h0000_0300);
      do_commit("R4 dead again");
      wr(3'd1, 32'd0);
      wr(3'd0, 32'd1);
      wr(3'd0, 32'd0);
      rd(3'd0, v);
      check("R4 zero write keeps flag", v[0], 1);
      for (int i = 0; i < 400 && !cleared; i++) begin
         rd(3'd0, v);
         if (!v[0]) cleared = 1'b1;
      end
      check("R4 flag cleared once idle", cleared, 1);
      repeat (40) @(negedge clk);
      rate("R4 rate after late commit", 200, 100);
   endtask

   task automatic t_safe();
      wr(3'd1, 32'h0000_0100);
      do_commit("R11 park");
      rate("R11 parked on safe source", 400, 100);
      wr(3'd2, 32'd1);
      wr(3'd3, ~32'd2);
      wr(3'd4, ~32'd3);
      wr(3'd1, 32'h0000_1202);
      do_commit("R11 target");
      rate("R11 target rate", 540, 20);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual 0 expected 1 (run completion)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_shadow();
      t_src();
      t_mnd();
      t_bypass();
      t_duty();
      t_idle();
      t_safe();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule